// File: doc/BRIEF.md
# Normalizing Barrel Shifter Unit

This unit shifts 16-bit two's-complement words and handles their numeric format. It places the input word in the upper or lower half of a 32-bit field and shifts that field left or right by a signed count. Four shift variants are available: logical shift, arithmetic shift, normalize and denormalize. An exponent-detect operation counts the redundant sign bits of a word and reports that count negated. The shifted field goes into a 32-bit result register. The exponent goes into a separate register.

The unit handles block floating-point and multiword values as follows. Software first runs exponent-detect on the most significant word. It then normalizes each word of the value by that exponent, placing each word with the half select. An OR mode merges each new shift result into the result already held, so a wide value is built up word by word. Denormalize runs the same steps in reverse to return the value to fixed point.

Top module: `shf_norm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` and `exp_out` are cleared to zero on that edge.
- R2: Placement. With `hi_sel`=1 the word occupies field bits 31:16 and bits 15:0 are zero. With `hi_sel`=0 the word occupies bits 15:0. The upper half is then a copy of the word's bit 15 for arithmetic shift (op 3'b001) and zero for every other shift op.
- R3: Logical shift (op 3'b000). A positive `amount` shifts the field left and a negative one shifts it right, with zeros filling the vacated bits.
- R4: Arithmetic shift (op 3'b001). Left shifts fill with zeros. Right shifts fill with copies of field bit 31.
- R5: A shift magnitude of 32 or more gives all zeros. The one exception is an arithmetic right shift, which gives 32 copies of field bit 31. This holds for every count from -128 to 127.
- R6: Normalize (op 3'b010) shifts by the negated `amount`, so an exponent of -n shifts left by n. A right shift in this mode is arithmetic.
- R7: Denormalize (op 3'b011) shifts by `amount` as given. A right shift in this mode is arithmetic.
- R8: Exponent detect (op 3'b100) loads `exp_out` with minus the count of bits below bit 15 that match bit 15, counting down until the first mismatch. The range is 0 to -15, and all-zero and all-one words give -15.
- R9: Exponent detect leaves `result` unchanged, and the shift ops leave `exp_out` unchanged. Op codes 3'b101 to 3'b111 change neither register.
- R10: With `or_mode`=1, a shift op loads `result` with the bitwise OR of the new shifted field and the previous `result`. With `or_mode`=0 it loads the shifted field alone.
- R11: With `en` low, both registers hold their values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Update enable for both registers |
| op | input | 3 | Operation: 000 logical, 001 arithmetic, 010 normalize, 011 denormalize, 100 exponent detect |
| hi_sel | input | 1 | 1 places the word in the upper half of the field, 0 in the lower half |
| or_mode | input | 1 | 1 merges the shift result into the existing result |
| din | input | 16 | Operand word |
| amount | input | 8 | Signed shift count or exponent |
| result | output | 32 | Registered shift result |
| exp_out | output | 8 | Registered derived exponent, two's complement |

## Verification
Four properties are checked on every cycle. Both registers hold while the enable is low. Each operation leaves the other register untouched. The exponent stays within 0 to -15. OR mode never clears a bit that was already set in the result. Only the bench scenarios can show the shifted values themselves: placement, fill bits, counts of 32 and beyond, the negated count used by normalize, and the exponent of particular words. The bench compares each of these against a reference model built from the requirements.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes for the normalizing shifter.
// Assumes a 3-bit operation field; codes above SH_EXPDET are reserved.
package shf_pkg;
    typedef enum logic [2:0] {
        SH_LOGIC  = 3'b000,
        SH_ARITH  = 3'b001,
        SH_NORM   = 3'b010,
        SH_DENORM = 3'b011,
        SH_EXPDET = 3'b100
    } shf_op_e;
endpackage

// File: rtl/shf_place.sv
`timescale 1ns/1ps
// shf_place: places a DW-bit word in the upper or lower half of a
// 2*DW-bit field. For the lower half, the upper half is either the
// sign copy or zero. Purely combinational.
module shf_place #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   din,
    input  logic            hi_sel,
    input  logic            sign_ext,
    output logic [2*DW-1:0] field
);
    // Select the placement and the fill of the unused half.
    always_comb begin
        if (hi_sel)
            field = {din, {DW{1'b0}}};
        else
            field = {{DW{sign_ext & din[DW-1]}}, din};
    end
endmodule

// File: rtl/shf_barrel.sv
`timescale 1ns/1ps
// shf_barrel: bidirectional logarithmic barrel shifter. A signed count
// selects the direction (positive = left). The fill on right shifts is
// the top bit when arith is set and zero otherwise. Left shifts reuse
// the right-shift stages on the bit-reversed field.
// Assumes CW > $clog2(W) so that magnitudes of W and above are visible.
module shf_barrel #(
    parameter int W  = 32,
    parameter int CW = 9
) (
    input  logic [W-1:0]  field,
    input  logic [CW-1:0] cnt,
    input  logic          arith,
    output logic [W-1:0]  shifted
);
    localparam int          LOG = $clog2(W);
    localparam logic [CW-1:0] W_C = CW'(W);

    logic          go_left;
    logic [CW-1:0] mag;
    logic          big;
    logic          fill;
    logic [W-1:0]  src_rev;
    logic [W-1:0]  stage [0:LOG];
    logic [W-1:0]  rshift;
    logic [W-1:0]  rshift_rev;

    // Decode direction, magnitude, out-of-range flag and fill bit.
    always_comb begin
        go_left = ~cnt[CW-1];
        mag     = cnt[CW-1] ? (~cnt + 1'b1) : cnt;
        big     = (mag >= W_C);
        fill    = arith & field[W-1] & ~go_left;
    end

    for (genvar b = 0; b < W; b++) begin : g_rev_in
        assign src_rev[b] = field[W-1-b];
    end

    assign stage[0] = go_left ? src_rev : field;

    for (genvar i = 0; i < LOG; i++) begin : g_stage
        assign stage[i+1] = mag[i] ? {{(2**i){fill}}, stage[i][W-1:2**i]}
                                   : stage[i];
    end

    assign rshift = big ? {W{fill}} : stage[LOG];

    for (genvar b = 0; b < W; b++) begin : g_rev_out
        assign rshift_rev[b] = rshift[W-1-b];
    end

    assign shifted = go_left ? rshift_rev : rshift;
endmodule

// File: rtl/shf_expdet.sv
`timescale 1ns/1ps
// shf_expdet: counts the bits below the sign bit that equal it, up to
// the first mismatch, and returns the count negated in EW bits.
// Assumes EW is wide enough to hold -(DW-1).
module shf_expdet #(
    parameter int DW = 16,
    parameter int EW = 8
) (
    input  logic [DW-1:0] din,
    output logic [EW-1:0] exp_val
);
    logic [EW-1:0] run;
    logic          stop;

    // Scan from just below the sign bit toward bit 0.
    always_comb begin
        run  = '0;
        stop = 1'b0;
        for (int i = DW-2; i >= 0; i--) begin
            if (!stop && (din[i] == din[DW-1]))
                run = run + 1'b1;
            else
                stop = 1'b1;
        end
        exp_val = ~run + 1'b1;
    end
endmodule

// File: rtl/shf_norm_unit.sv
`timescale 1ns/1ps
// shf_norm_unit: top of the normalizing shifter. It places the operand,
// shifts it by a signed count (negated for normalize) and loads or
// ORs the result into a 2*DATA_W result register. Exponent detect
// loads a separate exponent register. Both registers update only
// when en is high and clear on synchronous active-low reset.
module shf_norm_unit #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [2:0]          op,
    input  logic                hi_sel,
    input  logic                or_mode,
    input  logic [DATA_W-1:0]   din,
    input  logic [CNT_W-1:0]    amount,
    output logic [2*DATA_W-1:0] result,
    output logic [CNT_W-1:0]    exp_out
);
    import shf_pkg::*;

    localparam int RES_W = 2 * DATA_W;
    localparam int EFF_W = CNT_W + 1;

    logic [RES_W-1:0] field;
    logic [RES_W-1:0] shifted;
    logic [EFF_W-1:0] cnt_ext;
    logic [EFF_W-1:0] cnt_eff;
    logic [CNT_W-1:0] exp_val;
    logic             is_shift;
    logic             is_exp;
    logic             use_sign;
    logic             arith;

    // Decode the operation into control signals and the effective count.
    always_comb begin
        is_shift = (op == SH_LOGIC) || (op == SH_ARITH) ||
                   (op == SH_NORM)  || (op == SH_DENORM);
        is_exp   = (op == SH_EXPDET);
        use_sign = (op == SH_ARITH);
        arith    = (op != SH_LOGIC);
        cnt_ext  = {amount[CNT_W-1], amount};
        cnt_eff  = (op == SH_NORM) ? (~cnt_ext + 1'b1) : cnt_ext;
    end

    shf_place #(.DW(DATA_W)) u_place (
        .din      (din),
        .hi_sel   (hi_sel),
        .sign_ext (use_sign),
        .field    (field)
    );

    shf_barrel #(.W(RES_W), .CW(EFF_W)) u_barrel (
        .field   (field),
        .cnt     (cnt_eff),
        .arith   (arith),
        .shifted (shifted)
    );

    shf_expdet #(.DW(DATA_W), .EW(CNT_W)) u_expdet (
        .din     (din),
        .exp_val (exp_val)
    );

    // Result register: load or merge a shift result when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (en && is_shift)
            result <= or_mode ? (result | shifted) : shifted;
    end

    // Exponent register: load the detected exponent when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_out <= '0;
        else if (en && is_exp)
            exp_out <= exp_val;
    end
endmodule

// File: rtl/shf_norm_unit_chk.sv
`timescale 1ns/1ps
// shf_norm_unit_chk: property checker bound to shf_norm_unit. It watches
// the ports only and assumes the op encoding from shf_pkg.
module shf_norm_unit_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic [2:0]          op,
    input logic                or_mode,
    input logic [2*DATA_W-1:0] result,
    input logic [CNT_W-1:0]    exp_out
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && (exp_out == '0));

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result) && $stable(exp_out));

    // R9
    exp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'b100) |=> $stable(result));

    // R9
    shift_keeps_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op != 3'b100) |=> $stable(exp_out));

    // R8
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(exp_out) <= 0) && ($signed(exp_out) >= -(DATA_W-1)));

    // R10
    or_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && or_mode && op[2] == 1'b0) |=>
            ((result & $past(result)) == $past(result)));
endmodule

bind shf_norm_unit shf_norm_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .op      (op),
    .or_mode (or_mode),
    .result  (result),
    .exp_out (exp_out)
);

// File: tb/tb_shf_norm_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one operation per cycle and
// queues the expected register values; the monitor compares after
// each rising edge.
module tb_shf_norm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  op = 3'b000;
    logic        hi_sel = 1'b0;
    logic        or_mode = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  amount = '0;
    logic [31:0] result;
    logic [7:0]  exp_out;

    int checks = 0;
    int errors = 0;
    logic        done = 1'b0;

    typedef struct {
        logic [31:0] r;
        logic [7:0]  e;
        string       tag;
    } exp_t;
    exp_t sb_q [$];

    logic [31:0] m_res = '0;
    logic [7:0]  m_exp = '0;

    shf_norm_unit dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .hi_sel(hi_sel),
        .or_mode(or_mode), .din(din), .amount(amount),
        .result(result), .exp_out(exp_out)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] m_shift(input logic [2:0] o, input logic h,
                                            input logic [15:0] d, input logic [7:0] a);
        logic [31:0] f;
        int c;
        if (h) f = {d, 16'h0000};
        else if (o == 3'b001) f = {{16{d[15]}}, d};
        else f = {16'h0000, d};
        c = int'($signed(a));
        if (o == 3'b010) c = -c;
        if (c >= 0) return (c >= 32) ? 32'h0 : (f << c);
        c = -c;
        if (o == 3'b000) return (c >= 32) ? 32'h0 : (f >> c);
        return (c >= 32) ? {32{f[31]}} : 32'($signed(f) >>> c);
    endfunction

    function automatic logic [7:0] m_expdet(input logic [15:0] d);
        int n = 0;
        int i = 14;
        while (i >= 0 && d[i] == d[15]) begin
            n++;
            i--;
        end
        return 8'(-n);
    endfunction

    task automatic go(input logic e, input logic [2:0] o, input logic h, input logic m,
                      input logic [15:0] d, input logic [7:0] a, input string tag);
        exp_t it;
        @(negedge clk);
        en = e; op = o; hi_sel = h; or_mode = m; din = d; amount = a;
        if (e && o <= 3'b011) m_res = m ? (m_res | m_shift(o, h, d, a)) : m_shift(o, h, d, a);
        if (e && o == 3'b100) m_exp = m_expdet(d);
        it.r = m_res; it.e = m_exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the registers one time unit after each rising edge.
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (result !== it.r || exp_out !== it.e) begin
                errors++;
                $display("FAIL %s: result=%h exp=%h expected result=%h exp=%h",
                         it.tag, result, exp_out, it.r, it.e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: finished=0 expected finished=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        en = 1'b1; op = 3'b000; hi_sel = 1'b1; din = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || exp_out !== 8'h0) begin
            errors++;
            $display("FAIL R1: result=%h exp=%h expected result=00000000 exp=00", result, exp_out);
        end
        en = 1'b0;
        rst_n = 1'b1;

        go(1, 3'b000, 1, 0, 16'hA5C3, 8'd0,   "R2 hi placement");
        go(1, 3'b000, 0, 0, 16'h8001, 8'd0,   "R2 lo zero fill");
        go(1, 3'b001, 0, 0, 16'h8001, 8'd0,   "R2 lo sign fill");
        go(1, 3'b010, 0, 0, 16'h8001, 8'd0,   "R2 norm lo zero fill");
        go(1, 3'b000, 0, 0, 16'h00F0, 8'd4,   "R3 logical left");
        go(1, 3'b000, 1, 0, 16'h8000, -8'sd4, "R3 logical right");
        go(1, 3'b000, 1, 0, 16'h1234, 8'd12,  "R3 logical left across top");
        go(1, 3'b001, 1, 0, 16'h8000, -8'sd4, "R4 arith right negative");
        go(1, 3'b001, 1, 0, 16'h4000, -8'sd9, "R4 arith right positive");
        go(1, 3'b001, 0, 0, 16'hC001, 8'd3,   "R4 arith left");
        go(1, 3'b000, 0, 0, 16'hFFFF, 8'd40,  "R5 left 40");
        go(1, 3'b000, 0, 0, 16'hFFFF, 8'd32,  "R5 left 32");
        go(1, 3'b000, 0, 0, 16'hFFFF, 8'd31,  "R5 left 31");
        go(1, 3'b001, 1, 0, 16'h8000, -8'sd100, "R5 arith right 100");
        go(1, 3'b001, 1, 0, 16'h7000, -8'sd32,  "R5 arith right 32 positive");
        go(1, 3'b000, 1, 0, 16'hFFFF, 8'h80,  "R5 logical right 128");
        go(1, 3'b000, 0, 0, 16'h0001, 8'd127, "R5 left 127");
        go(1, 3'b100, 0, 0, 16'h0123, 8'd0,   "R8 exponent of 0123");
        go(1, 3'b010, 1, 0, 16'h0123, 8'hFA,  "R6 normalize hi by -6");
        go(1, 3'b010, 1, 0, 16'h4000, 8'd2,   "R6 normalize positive count");
        go(1, 3'b010, 1, 0, 16'h8000, 8'd0,   "R6 normalize by zero");
        go(1, 3'b010, 1, 0, 16'h0012, 8'hF6,  "R10 normalize hi word");
        go(1, 3'b010, 0, 1, 16'hABCD, 8'hF6,  "R10 OR lo word");
        go(1, 3'b000, 0, 0, 16'h0F0F, 8'd0,   "R10 plain load replaces");
        go(1, 3'b000, 1, 1, 16'hF000, 8'd0,   "R10 OR hi word");
        go(1, 3'b011, 1, 0, 16'h9000, -8'sd3, "R7 denorm hi right");
        go(1, 3'b011, 0, 0, 16'h9000, -8'sd3, "R7 denorm lo right");
        go(1, 3'b011, 0, 0, 16'h9000, 8'd4,   "R7 denorm left");
        go(1, 3'b100, 0, 0, 16'h4000, 8'd0,   "R8 exponent 4000");
        go(1, 3'b100, 0, 0, 16'h0001, 8'd0,   "R8 exponent 0001");
        go(1, 3'b100, 0, 0, 16'hFFFF, 8'd0,   "R8 exponent FFFF");
        go(1, 3'b100, 0, 0, 16'h0000, 8'd0,   "R8 exponent 0000");
        go(1, 3'b100, 1, 0, 16'hC000, 8'd0,   "R8 exponent C000");
        go(1, 3'b100, 0, 0, 16'hFF7F, 8'd0,   "R8 exponent FF7F");
        go(1, 3'b000, 1, 0, 16'h0055, 8'd1,   "R9 shift keeps exponent");
        go(1, 3'b100, 0, 0, 16'h3FFF, 8'd0,   "R9 exponent keeps result");
        go(1, 3'b101, 1, 0, 16'hFFFF, 8'd5,   "R9 reserved 101");
        go(1, 3'b110, 0, 1, 16'hFFFF, 8'd5,   "R9 reserved 110");
        go(1, 3'b111, 0, 0, 16'h0001, 8'd0,   "R9 reserved 111");
        go(0, 3'b000, 1, 0, 16'hFFFF, 8'd0,   "R11 idle shift");
        go(0, 3'b100, 0, 0, 16'h0001, 8'd0,   "R11 idle exponent");
        go(0, 3'b010, 0, 1, 16'hFFFF, 8'hF0,  "R11 idle or");
        go(0, 3'b000, 0, 0, 16'h0000, 8'd0,   "R11 settle");

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule